// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Interface

This block sits between a 16-bit register bus and four 12-bit digital-to-analog converters. It holds one data register per channel, a mode register that enables the converters and selects between direct and buffered updates, and a range register that carries a bipolar bit and a gain bit for each channel. Each code and each range bit it presents to the converters comes straight from a flip-flop.

In direct mode, a write to a channel's data register changes that channel's output code on the next clock edge. In buffered mode, writes only stage new codes. A read of the mode register then moves every staged code to the outputs on the same edge, so all channels change together. Range bits are always staged. They reach the converters only when the host reads the range register. In both cases the read strobe does the work and the read data is not used. While the converters are disabled, every output sits at mid-scale and data writes are dropped.

Top module: `dac_quad_if`

## Requirements
- R1: After reset, every output code is mid-scale (0x800), all range outputs are 0, the block is disabled and unbuffered, and all staged and applied codes are 0, so enabling the block without any data write shows code 0 on every channel.
- R2: A write to offset 0x02 sets the enable flag from data bit 1 and the buffered flag from data bit 0. The other data bits have no effect.
- R3: While the enable flag is clear, every output code is 0x800. When the flag is set, each channel shows its applied code.
- R4: A data register write made while the block is disabled is dropped. Neither the staged code nor the applied code of that channel changes.
- R5: When the block is enabled and not buffered, a write to the data register of channel n (offset 0x14 + 2n) changes only that channel's output code, on the clock edge that samples the write.
- R6: When the block is enabled and buffered, a data register write changes the channel's staged code but leaves every output code unchanged.
- R7: When the block is enabled and buffered, a read of offset 0x02 copies all four staged codes to the outputs on the same edge. The same read has no effect when the block is unbuffered or disabled.
- R8: A write to offset 0x12 stages, for channel n, a bipolar bit from data bit 7-n and a gain bit from data bit 11-n. The range outputs change only when offset 0x12 is read, and then all of them change at once, whether or not the block is enabled.
- R9: Writes and reads at offsets other than 0x02, 0x12 and 0x14 + 2n (for example 0x15 or 0x00) change no state and no output.
- R10: A data register write uses only bits 11:0 of the write data. Bits 15:12 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; commits staged state |
| dac_code | output | 48 | Four 12-bit output codes, channel n at bits 12n+11:12n |
| rng_bipolar | output | 4 | Applied bipolar select, bit n for channel n |
| rng_gain | output | 4 | Applied gain select, bit n for channel n |

## Verification
The bench builds the block with its default parameters: four channels, 12-bit codes, a 16-bit bus and an 8-bit offset. With four channels the mirrored range fields fill bits 4 to 11 completely, with the bipolar field directly below the gain field. A wrong offset or a reversed channel order in either field therefore lands on a neighbouring channel's bit, or in the other field, and the outputs show it. The 12-bit code inside a 16-bit bus word lets the bench drive ones into the four unused upper bits. The directed part walks the reset, disabled, direct and buffered states in a fixed order. The random part mixes every legal offset with unused ones, so commits happen while data is partly staged and range writes and reads fall between data writes.

// File: rtl/dac_quad_pkg.sv
package dac_quad_pkg;

    // Register offsets (byte addresses) seen by the host.
    localparam int unsigned MODE_OFS    = 'h02;
    localparam int unsigned RANGE_OFS   = 'h12;
    localparam int unsigned DATA_BASE   = 'h14;
    localparam int unsigned DATA_STRIDE = 2;

    // Mode register fields.
    localparam int unsigned EN_BIT  = 1;
    localparam int unsigned BUF_BIT = 0;

    // Range register: channel n sits at (TOP - n) in each field.
    localparam int unsigned BIP_TOP  = 7;
    localparam int unsigned GAIN_TOP = 11;

    // Decoded bus access for the shared registers.
    typedef struct packed {
        logic mode_wr;
        logic mode_rd;
        logic rng_wr;
        logic rng_rd;
    } shared_hit_t;

endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
    import dac_quad_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output shared_hit_t       shared_hit,
    output logic [NUM_CH-1:0] data_wr
);

    localparam logic [ADDR_W-1:0] MODE_A  = ADDR_W'(MODE_OFS);
    localparam logic [ADDR_W-1:0] RANGE_A = ADDR_W'(RANGE_OFS);

    always_comb begin
        shared_hit         = '0;
        shared_hit.mode_wr = bus_wr && (bus_addr == MODE_A);
        shared_hit.mode_rd = bus_rd && (bus_addr == MODE_A);
        shared_hit.rng_wr  = bus_wr && (bus_addr == RANGE_A);
        shared_hit.rng_rd  = bus_rd && (bus_addr == RANGE_A);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_data_hit
        localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(DATA_BASE + DATA_STRIDE * g);
        assign data_wr[g] = bus_wr && (bus_addr == CH_A);
    end

endmodule

// File: rtl/dac_mode_regs.sv
module dac_mode_regs
    import dac_quad_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shared_hit_t       shared_hit,
    input  logic [BUS_W-1:0]  wdata,
    output logic              en_q,
    output logic              en_d,
    output logic              buffered_q,
    output logic              commit,
    output logic [NUM_CH-1:0] rng_bipolar,
    output logic [NUM_CH-1:0] rng_gain
);

    typedef struct packed {
        logic              en;
        logic              buffered;
        logic [NUM_CH-1:0] bip_stage;
        logic [NUM_CH-1:0] gain_stage;
        logic [NUM_CH-1:0] bip;
        logic [NUM_CH-1:0] gain;
    } mode_state_t;

    mode_state_t st_d, st_q;

    // Bits of the bus word that no field of these registers occupies.
    logic unused_wbits;
    assign unused_wbits = ^{wdata[BUS_W-1:GAIN_TOP+1], wdata[BIP_TOP-NUM_CH:EN_BIT+1]};

    always_comb begin
        st_d = st_q;
        if (shared_hit.mode_wr) begin
            st_d.en       = wdata[EN_BIT];
            st_d.buffered = wdata[BUF_BIT];
        end
        if (shared_hit.rng_wr) begin
            for (int n = 0; n < NUM_CH; n++) begin
                st_d.bip_stage[n]  = wdata[BIP_TOP - n];
                st_d.gain_stage[n] = wdata[GAIN_TOP - n];
            end
        end
        if (shared_hit.rng_rd) begin
            st_d.bip  = st_q.bip_stage;
            st_d.gain = st_q.gain_stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q        = st_q.en;
    assign en_d        = st_d.en;
    assign buffered_q  = st_q.buffered;
    assign commit      = shared_hit.mode_rd && st_q.en && st_q.buffered;
    assign rng_bipolar = st_q.bip;
    assign rng_gain    = st_q.gain;

    // R8
    range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_hit.rng_rd |=> ($stable(rng_bipolar) && $stable(rng_gain)));

    // R8
    range_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_hit.rng_rd && !shared_hit.rng_wr) |=>
            (rng_bipolar == $past(st_q.bip_stage) && rng_gain == $past(st_q.gain_stage)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_hit.mode_wr |=> ($stable(en_q) && $stable(buffered_q)));

endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              en_d,
    input  logic              buffered_q,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output logic [DATA_W-1:0] code
);

    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] staged;
        logic [DATA_W-1:0] applied;
        logic [DATA_W-1:0] code;
    } slot_state_t;

    slot_state_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (wr_hit && en_q) begin
            sl_d.staged = wdata;
        end
        if (commit) begin
            sl_d.applied = sl_q.staged;
        end
        if (wr_hit && en_q && !buffered_q) begin
            sl_d.applied = wdata;
        end
        sl_d.code = en_d ? sl_d.applied : MID_CODE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl_q.staged  <= '0;
            sl_q.applied <= '0;
            sl_q.code    <= MID_CODE;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign code = sl_q.code;

    // R3
    disabled_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_d |=> (code == MID_CODE));

    // R4
    drop_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !en_q) |=> ($stable(sl_q.staged) && $stable(sl_q.applied)));

    // R5
    direct_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && en_q && !buffered_q) |=> (code == $past(wdata)));

    // R6
    staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && en_q && buffered_q && !commit) |=> $stable(code));

    // R7
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_hit) |=> (sl_q.applied == $past(sl_q.staged)));

endmodule

// File: rtl/dac_quad_if.sv
module dac_quad_if
    import dac_quad_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [NUM_CH*DATA_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        rng_bipolar,
    output logic [NUM_CH-1:0]        rng_gain
);

    shared_hit_t       shared_hit;
    logic [NUM_CH-1:0] data_wr;
    logic              en_q;
    logic              en_d;
    logic              buffered_q;
    logic              commit;

    dac_bus_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .shared_hit (shared_hit),
        .data_wr    (data_wr)
    );

    dac_mode_regs #(
        .NUM_CH (NUM_CH),
        .BUS_W  (BUS_W)
    ) i_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .shared_hit  (shared_hit),
        .wdata       (bus_wdata),
        .en_q        (en_q),
        .en_d        (en_d),
        .buffered_q  (buffered_q),
        .commit      (commit),
        .rng_bipolar (rng_bipolar),
        .rng_gain    (rng_gain)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        dac_chan_slot #(
            .DATA_W (DATA_W)
        ) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_q       (en_q),
            .en_d       (en_d),
            .buffered_q (buffered_q),
            .wr_hit     (data_wr[g]),
            .wdata      (bus_wdata[DATA_W-1:0]),
            .commit     (commit),
            .code       (dac_code[g*DATA_W +: DATA_W])
        );
    end

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !bus_rd) |=> ($stable(dac_code) && $stable(rng_bipolar) && $stable(rng_gain)));

endmodule

// File: tb/test_dac_quad_if.sv
`timescale 1ns/1ps
module test_dac_quad_if;

    localparam int NCH = 4;
    localparam int DW  = 12;
    localparam logic [DW-1:0] MID = 12'h800;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [7:0]         bus_addr = '0;
    logic [15:0]        bus_wdata = '0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [NCH*DW-1:0]  dac_code;
    logic [NCH-1:0]     rng_bipolar;
    logic [NCH-1:0]     rng_gain;

    int total = 0;
    int bad   = 0;

    // Reference state kept by the bench.
    logic [DW-1:0] m_stage [NCH];
    logic [DW-1:0] m_appl  [NCH];
    bit            m_en, m_buf;
    logic [NCH-1:0] m_sb, m_sg, m_rb, m_rg;

    always #2 clk = ~clk;

    dac_quad_if i_dac_quad_if (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .dac_code    (dac_code),
        .rng_bipolar (rng_bipolar),
        .rng_gain    (rng_gain)
    );

    function automatic logic [DW-1:0] exp_code(int n);
        return m_en ? m_appl[n] : MID;
    endfunction

    function automatic int data_chan(logic [7:0] a);
        for (int n = 0; n < NCH; n++) begin
            if (a == 8'(8'h14 + 2 * n)) return n;
        end
        return -1;
    endfunction

    function automatic void model_write(logic [7:0] a, logic [15:0] d);
        int ch;
        ch = data_chan(a);
        if (a == 8'h02) begin
            m_en  = d[1];
            m_buf = d[0];
        end else if (a == 8'h12) begin
            for (int n = 0; n < NCH; n++) begin
                m_sb[n] = d[7 - n];
                m_sg[n] = d[11 - n];
            end
        end else if (ch >= 0 && m_en) begin
            m_stage[ch] = d[11:0];
            if (!m_buf) m_appl[ch] = d[11:0];
        end
    endfunction

    function automatic void model_read(logic [7:0] a);
        if (a == 8'h12) begin
            m_rb = m_sb;
            m_rg = m_sg;
        end else if (a == 8'h02 && m_en && m_buf) begin
            for (int n = 0; n < NCH; n++) m_appl[n] = m_stage[n];
        end
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int n = 0; n < NCH; n++) begin
            check(tag, 32'(dac_code[n*DW +: DW]), 32'(exp_code(n)));
        end
        check(tag, 32'(rng_bipolar), 32'(m_rb));
        check(tag, 32'(rng_gain), 32'(m_rg));
    endtask

    // Drive one strobe at a falling edge; outputs settle after the next rising edge.
    task automatic op_write(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic op_read(logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        model_read(a);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned r;
        logic [7:0] addrs [8];
        for (int n = 0; n < NCH; n++) begin
            m_stage[n] = '0;
            m_appl[n]  = '0;
        end
        m_en = 0; m_buf = 0; m_sb = '0; m_sg = '0; m_rb = '0; m_rg = '0;
        addrs = '{8'h02, 8'h12, 8'h14, 8'h16, 8'h18, 8'h1A, 8'h15, 8'h00};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R4: write while disabled is dropped; R3: outputs stay mid-scale.
        op_write(8'h14, 16'h0123);
        check_all("R4 disabled write");
        op_write(8'h02, 16'hFFFE);          // R2: enable, unbuffered, other bits set
        check_all("R1 R2 enable shows zero");
        check(  "R4 dropped value", 32'(dac_code[11:0]), 32'h000);

        // R5: direct update of a single channel.
        op_write(8'h18, 16'h0ABC);
        check_all("R5 direct write");

        // R6 / R7: buffered staging and commit.
        op_write(8'h02, 16'h0003);
        op_write(8'h16, 16'h0123);
        op_write(8'h1A, 16'h0FED);
        check_all("R6 staged no change");
        op_read(8'h02);
        check_all("R7 commit");
        check("R7 ch3 committed", 32'(dac_code[47:36]), 32'hFED);

        // R10: upper data bits ignored (direct mode).
        op_write(8'h02, 16'h0002);
        op_write(8'h14, 16'hF5A5);
        check_all("R10 low bits only");

        // R9: odd and unmapped offsets.
        op_write(8'h15, 16'h0777);
        op_write(8'h00, 16'h0000);
        op_read(8'h1C);
        check_all("R9 unmapped ignored");

        // R8: range staging and apply while disabled.
        op_write(8'h02, 16'h0000);
        op_write(8'h12, 16'h0A50);
        check_all("R8 range staged");
        op_read(8'h12);
        check_all("R8 range applied");
        check("R8 gain bits", 32'(rng_gain), 32'h5);
        check("R8 bipolar bits", 32'(rng_bipolar), 32'hA);
        check_all("R3 disabled mid-scale");

        // R7: read of mode register in unbuffered mode has no effect.
        op_write(8'h02, 16'h0003);
        op_write(8'h18, 16'h0444);
        op_write(8'h02, 16'h0002);
        op_read(8'h02);
        check_all("R7 unbuffered read no effect");

        // Random mix.
        r = $urandom(32'd1357);
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  a;
            logic [15:0] d;
            a = addrs[$urandom % 8];
            d = 16'($urandom);
            if ($urandom % 3 == 0) begin
                op_read(a);
                check_all(a == 8'h12 ? "R8 random read" : "R7 random read");
            end else begin
                op_write(a, d);
                if (a == 8'h02) check_all("R2 random mode");
                else if (a == 8'h12) check_all("R8 random range");
                else if (data_chan(a) < 0) check_all("R9 random unmapped");
                else if (!m_en) check_all("R4 random dropped");
                else if (m_buf) check_all("R6 random staged");
                else check_all("R5 random direct");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule